// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Sequencer

This block turns single-word requests from an internal master into timed read and write cycles for an external asynchronous SRAM, ROM or NOR-type memory. A request is taken only while the sequencer is idle. The address, the write data, the direction and the complete timing configuration are captured at that point. The access then runs through up to four phases, each counted in system clock cycles: address setup, address hold (used only when address and data share pins), data, and a bus turnaround gap. A one-cycle completion pulse follows the gap.

The phase lengths, the multiplexed mode, the external data width, a write-inhibit control and an optional wait input with selectable polarity are all runtime configuration inputs. When writes are inhibited, a write request still runs its full timing. It never pulses the write strobe, it leaves the data pins undriven, and it reports an error together with completion. The data pins are brought out as a split tri-state driver: an output value, an output enable and an input.

Top module: `sram_phase_seq`

## Requirements
- R1: After reset, the chip select, output enable, write enable and address-latch strobes (all active low) are high, the data-pin enable is low, and done_o and err_o are low.
- R2: A request taken in the idle state starts the access on the next cycle. The address setup phase lasts cfg_addr_setup_i cycles (0 to 15), and a value of 0 skips the phase.
- R3: With cfg_mux_i=1, an address hold phase of cfg_addr_hold_i cycles follows setup, with 0 treated as 1. The address-latch strobe is low through setup and hold, and during those phases the data pins drive the address, zero-extended and masked to the data width. With cfg_mux_i=0 there is no hold phase and the strobe stays high.
- R4: The data phase lasts cfg_data_len_i cycles (1 to 255), with 0 treated as 1. Output enable is low only during the data phase of a read, and write enable is low only during the data phase of a permitted write. The two are never low together.
- R5: After the data phase, cfg_turn_i cycles (0 to 15) pass with every strobe high and the data pins released. done_o is then high for exactly one cycle, and chip select is high in that cycle.
- R6: A permitted write drives the masked write data on the data pins for the whole data phase. A read keeps the data pins released for the whole access, except for the multiplexed address phases.
- R7: cfg_width_i selects the external width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. Data-pin bits above the width are driven as 0, and read data above the width is returned as 0.
- R8: A read captures the data pins on the last cycle of its data phase into rdata_o. The value stays there until the next read completes.
- R9: With cfg_wr_en_i=0, a write request keeps write enable high and the data pins released through the whole access, and err_o is high in the done_o cycle. err_o is low in the done_o cycle of every other access.
- R10: With cfg_wait_en_i=1, the wait input (active high when cfg_wait_pol_i=1, active low when 0) passes through a 2-flop synchronizer. The data phase ends only once its programmed length has elapsed and the synchronized wait is inactive. A release in the middle of data cycle Q therefore gives max(length, Q+3) data cycles. With cfg_wait_en_i=0, the wait input has no effect.
- R11: Requests, address, write data and configuration inputs that change during an access have no effect on it. The external address stays stable while chip select is low.
- R12: Chip select is low continuously from the first setup or hold cycle through the last data cycle, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken only while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid from done_o |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Inhibited write, valid with done_o |
| cfg_addr_setup_i | input | 4 | Address setup cycles |
| cfg_addr_hold_i | input | 4 | Address hold cycles (multiplexed mode) |
| cfg_data_len_i | input | 8 | Data phase cycles |
| cfg_turn_i | input | 4 | Turnaround cycles |
| cfg_mux_i | input | 1 | Address on data pins |
| cfg_wr_en_i | input | 1 | Writes permitted |
| cfg_width_i | input | 2 | External data width code |
| cfg_wait_en_i | input | 1 | Wait input honoured |
| cfg_wait_pol_i | input | 1 | Wait active level |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_adv_no | output | 1 | Address-latch strobe, active low |
| mem_addr_o | output | ADDR_W | External address |
| mem_dq_o | output | DATA_W | Data-pin output value |
| mem_dq_oe_o | output | 1 | Data-pin output enable |
| mem_dq_i | input | DATA_W | Data-pin input value |
| mem_wait_i | input | 1 | Asynchronous wait from memory |

## Verification
The access begins on the cycle after the accepting edge. Every strobe and the data pins are sampled at each falling edge, and the bench counts how many samples fall in each phase, so the expected lengths S, max(H,1), max(D,1) and T are compared cycle for cycle. done_o is due on the cycle after the turnaround's last cycle. The next sample must show it low, and rdata_o and err_o are read in the same done_o sample. For the wait tests, the bench releases the wait input in the middle of a known data cycle Q and expects max(D, Q+3) data cycles. Those three extra cycles are the two synchronizer flops plus the cycle in which the phase ends.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int PH_W  = 4;   // setup, hold and turnaround fields
  localparam int DL_W  = 8;   // data phase field
  localparam int CNT_W = DL_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASET,
    ST_AHLD,
    ST_DATA,
    ST_TURN
  } sps_state_e;

  typedef struct packed {
    logic [PH_W-1:0] aset;
    logic [PH_W-1:0] ahld;
    logic [DL_W-1:0] dlen;
    logic [PH_W-1:0] turn;
    logic            mux;
    logic            wr_en;
    logic [1:0]      width;
    logic            wait_en;
    logic            wait_pol;
  } sps_cfg_t;
endpackage

// File: rtl/sps_wait_sync.sv
module sps_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic en_i,
  input  logic pol_i,
  output logic act_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], wait_i};
  end

  assign act_o = en_i & (sync_q[STAGES-1] == pol_i);
endmodule

// File: rtl/sps_lane_mask.sv
module sps_lane_mask #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        width_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam int LANES = DATA_W / 8;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic on;
    always_comb begin
      unique case (width_i)
        2'd0:    on = (l == 0);
        2'd1:    on = (l < 2);
        default: on = 1'b1;
      endcase
    end
    assign mask_o[l*8 +: 8] = {8{on}};
  end
endmodule

// File: rtl/sps_fsm.sv
module sps_fsm
  import sps_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  sps_cfg_t   cfg_i,
  input  logic       wait_act_i,
  output logic       accept_o,
  output sps_state_e state_o,
  output sps_cfg_t   cfg_q_o,
  output logic       last_data_o,
  output logic       done_o
);
  sps_state_e       st_q, nxt_st;
  logic [CNT_W-1:0] cnt_q, nxt_cnt;
  sps_cfg_t         cfg_q;
  logic             done_q, done_d;

  function automatic logic [CNT_W-1:0] hold_ld(sps_cfg_t c);
    return (c.ahld == '0) ? '0 : CNT_W'(c.ahld) - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] data_ld(sps_cfg_t c);
    return (c.dlen == '0) ? '0 : CNT_W'(c.dlen) - 1'b1;
  endfunction

  assign accept_o    = (st_q == ST_IDLE) && req_i;
  assign last_data_o = (st_q == ST_DATA) && (cnt_q == '0) && !wait_act_i;

  always_comb begin
    nxt_st  = st_q;
    nxt_cnt = cnt_q;
    done_d  = 1'b0;
    if (st_q != ST_IDLE && cnt_q != '0) nxt_cnt = cnt_q - 1'b1;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        if (cfg_i.aset != '0) begin
          nxt_st  = ST_ASET;
          nxt_cnt = CNT_W'(cfg_i.aset) - 1'b1;
        end else if (cfg_i.mux) begin
          nxt_st  = ST_AHLD;
          nxt_cnt = hold_ld(cfg_i);
        end else begin
          nxt_st  = ST_DATA;
          nxt_cnt = data_ld(cfg_i);
        end
      end
      ST_ASET: if (cnt_q == '0) begin
        if (cfg_q.mux) begin
          nxt_st  = ST_AHLD;
          nxt_cnt = hold_ld(cfg_q);
        end else begin
          nxt_st  = ST_DATA;
          nxt_cnt = data_ld(cfg_q);
        end
      end
      ST_AHLD: if (cnt_q == '0) begin
        nxt_st  = ST_DATA;
        nxt_cnt = data_ld(cfg_q);
      end
      ST_DATA: if (last_data_o) begin
        if (cfg_q.turn != '0) begin
          nxt_st  = ST_TURN;
          nxt_cnt = CNT_W'(cfg_q.turn) - 1'b1;
        end else begin
          nxt_st = ST_IDLE;
          done_d = 1'b1;
        end
      end
      ST_TURN: if (cnt_q == '0) begin
        nxt_st = ST_IDLE;
        done_d = 1'b1;
      end
      default: nxt_st = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= nxt_st;
      cnt_q  <= nxt_cnt;
      done_q <= done_d;
      if (accept_o) cfg_q <= cfg_i;
    end
  end

  assign state_o = st_q;
  assign cfg_q_o = cfg_q;
  assign done_o  = done_q;
endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sps_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              err_o,
  input  logic [PH_W-1:0]   cfg_addr_setup_i,
  input  logic [PH_W-1:0]   cfg_addr_hold_i,
  input  logic [DL_W-1:0]   cfg_data_len_i,
  input  logic [PH_W-1:0]   cfg_turn_i,
  input  logic              cfg_mux_i,
  input  logic              cfg_wr_en_i,
  input  logic [1:0]        cfg_width_i,
  input  logic              cfg_wait_en_i,
  input  logic              cfg_wait_pol_i,
  output logic              mem_cs_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              mem_adv_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  input  logic              mem_wait_i
);
  sps_cfg_t          cfg_in, cfg_q;
  sps_state_e        st;
  logic              accept, last_data, done, wait_act;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, mask;
  logic              we_q, err_q;
  logic              wr_ok, addr_ph, data_ph;

  assign cfg_in = '{aset:     cfg_addr_setup_i,
                    ahld:     cfg_addr_hold_i,
                    dlen:     cfg_data_len_i,
                    turn:     cfg_turn_i,
                    mux:      cfg_mux_i,
                    wr_en:    cfg_wr_en_i,
                    width:    cfg_width_i,
                    wait_en:  cfg_wait_en_i,
                    wait_pol: cfg_wait_pol_i};

  sps_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .cfg_i       (cfg_in),
    .wait_act_i  (wait_act),
    .accept_o    (accept),
    .state_o     (st),
    .cfg_q_o     (cfg_q),
    .last_data_o (last_data),
    .done_o      (done)
  );

  sps_wait_sync #(.STAGES(2)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wait_i (mem_wait_i),
    .en_i   (cfg_q.wait_en),
    .pol_i  (cfg_q.wait_pol),
    .act_o  (wait_act)
  );

  sps_lane_mask #(.DATA_W(DATA_W)) u_mask (
    .width_i (cfg_q.width),
    .mask_o  (mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        we_q    <= we_i;
      end
      if (last_data && !we_q) rdata_q <= mem_dq_i & mask;
      // error flag shares the cycle of the done pulse
      err_q <= last_data && (cfg_q.turn == '0) && we_q && !cfg_q.wr_en ||
               (st == ST_TURN && !done && err_pend);
    end
  end

  // blocked-write marker carried through the turnaround gap
  logic err_pend;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_pend <= 1'b0;
    else if (accept) err_pend <= we_i && !cfg_wr_en_i;
  end

  assign wr_ok   = we_q && cfg_q.wr_en;
  assign addr_ph = (st == ST_ASET) || (st == ST_AHLD);
  assign data_ph = (st == ST_DATA);

  always_comb begin
    mem_dq_o    = '0;
    mem_dq_oe_o = 1'b0;
    if (addr_ph && cfg_q.mux) begin
      mem_dq_o    = DATA_W'(addr_q) & mask;
      mem_dq_oe_o = 1'b1;
    end else if (data_ph && wr_ok) begin
      mem_dq_o    = wdata_q & mask;
      mem_dq_oe_o = 1'b1;
    end
  end

  assign mem_cs_no  = !(addr_ph || data_ph);
  assign mem_oe_no  = !(data_ph && !we_q);
  assign mem_we_no  = !(data_ph && wr_ok);
  assign mem_adv_no = !(addr_ph && cfg_q.mux);
  assign mem_addr_o = addr_q;
  assign rdata_o    = rdata_q;
  assign done_o     = done;
  assign err_o      = err_q && done;
endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              adv_n,
  input logic              dq_oe,
  input logic              done,
  input logic              err,
  input logic [ADDR_W-1:0] addr
);
  p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_n && !we_n));

  p_strobe_in_cs_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_n || !we_n || !adv_n) |-> !cs_n);

  p_adv_no_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_n |-> (oe_n && we_n));

  p_read_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n |-> !dq_oe);

  p_gap_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n |-> !dq_oe);

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> cs_n);

  p_err_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err |-> done);

  p_addr_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n && $past(!cs_n)) |-> $stable(addr));
endmodule

bind sram_phase_seq sps_checker #(.ADDR_W(ADDR_W)) u_sps_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_n   (mem_cs_no),
  .oe_n   (mem_oe_no),
  .we_n   (mem_we_no),
  .adv_n  (mem_adv_no),
  .dq_oe  (mem_dq_oe_o),
  .done   (done_o),
  .err    (err_o),
  .addr   (mem_addr_o)
);

// File: tb/sram_phase_seq_tb_top.sv
`timescale 1ns/1ps
module sram_phase_seq_tb_top;
  localparam int AW = 24;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          done, err;
  logic [3:0]    c_set = 0, c_hld = 0, c_turn = 0;
  logic [7:0]    c_dat = 1;
  logic          c_mux = 0, c_wen = 1, c_wen_pol = 0, c_wait_en = 0, c_wait_pol = 0;
  logic [1:0]    c_width = 2;
  logic          cs_n, oe_n, we_n, adv_n, dq_oe;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] dq_o, dq_i;
  logic          m_wait = 1'b0;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] model(logic [AW-1:0] a);
    return (DW'(a) * 32'h9E37_79B1) ^ 32'hC3A5_5A3C;
  endfunction

  function automatic logic [DW-1:0] wmask(logic [1:0] w);
    return (w == 2'd0) ? 32'h0000_00FF : (w == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  assign dq_i = model(m_addr);

  sram_phase_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .err_o(err),
    .cfg_addr_setup_i(c_set), .cfg_addr_hold_i(c_hld), .cfg_data_len_i(c_dat),
    .cfg_turn_i(c_turn), .cfg_mux_i(c_mux), .cfg_wr_en_i(c_wen),
    .cfg_width_i(c_width), .cfg_wait_en_i(c_wait_en), .cfg_wait_pol_i(c_wait_pol),
    .mem_cs_no(cs_n), .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_adv_no(adv_n),
    .mem_addr_o(m_addr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i),
    .mem_wait_i(m_wait)
  );

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // one access; wq >= 0 releases wait in the middle of data cycle wq
  task automatic run(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic hold_req, input int wq);
    int s, h, dl, t, e_cs, e_adv, e_oe, e_we, n_cs, n_adv, n_oe, n_we, n_gap, tmo;
    logic blk, bad_dq, bad_addr, seen_cs;
    logic [DW-1:0] m, e_rd;
    logic [7:0] sv_dat;
    s   = int'(c_set);
    h   = c_mux ? ((c_hld == 0) ? 1 : int'(c_hld)) : 0;
    dl  = (c_dat == 0) ? 1 : int'(c_dat);
    if (c_wait_en && wq >= 0 && dl < wq + 3) dl = wq + 3;
    t   = int'(c_turn);
    blk = w && !c_wen;
    m   = wmask(c_width);
    e_cs = s + h + dl; e_adv = c_mux ? s + h : 0;
    e_oe = w ? 0 : dl; e_we = (w && !blk) ? dl : 0;
    e_rd = w ? rdata : (model(a) & m);
    if (c_wait_en) begin
      m_wait = c_wait_pol;
      @(negedge clk); @(negedge clk);
    end
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    sv_dat = c_dat;
    if (hold_req) begin
      addr = ~a; wdata = ~d; we = ~w; c_dat = c_dat + 8'd7;
    end else req = 1'b0;
    n_cs = 0; n_adv = 0; n_oe = 0; n_we = 0; n_gap = 0; tmo = 0;
    bad_dq = 0; bad_addr = 0; seen_cs = 0;
    while (!done && tmo < 3000) begin
      if (!cs_n) begin
        if (c_wait_en && wq >= 0 && n_cs == s + h + wq) m_wait = ~c_wait_pol;
        n_cs++; seen_cs = 1;
        if (m_addr !== a) bad_addr = 1;
      end else if (seen_cs) n_gap++;
      if (!adv_n) begin n_adv++; if (!dq_oe || dq_o !== (DW'(a) & m)) bad_dq = 1; end
      if (!oe_n) begin n_oe++; if (dq_oe) bad_dq = 1; end
      if (!we_n) begin n_we++; if (!dq_oe || dq_o !== (d & m)) bad_dq = 1; end
      if (cs_n && dq_oe) bad_dq = 1;
      if (!cs_n && adv_n && we_n && dq_oe) bad_dq = 1;
      @(negedge clk); tmo++;
    end
    req = 1'b0; c_dat = sv_dat;
    check(tmo < 3000, "R5 done timeout", tmo, 0);
    check(n_cs == e_cs, "R2/R12 cs low cycles", n_cs, e_cs);
    check(n_adv == e_adv, "R3 latch strobe cycles", n_adv, e_adv);
    check(n_oe == e_oe, c_wait_en ? "R10 read data cycles" : "R4 oe cycles", n_oe, e_oe);
    check(n_we == e_we, blk ? "R9 we blocked" : "R4 we cycles", n_we, e_we);
    check(n_gap == t, "R5 turnaround cycles", n_gap, t);
    check(!bad_dq, "R6/R7 data pin content", bad_dq, 0);
    check(!bad_addr, "R11 address held", bad_addr, 0);
    check(rdata === e_rd, "R8/R7 read data", rdata, e_rd);
    check(err === blk, "R9 err with done", err, blk);
    @(negedge clk);
    check(!done, "R5 done single cycle", done, 0);
  endtask

  initial begin
    #(8ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=1 exp=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5150));
    #20;
    @(negedge clk);
    check(cs_n && oe_n && we_n && adv_n && !dq_oe && !done && !err,
          "R1 reset state", {cs_n, oe_n, we_n, adv_n, dq_oe, done, err}, 7'b1111000);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && oe_n && we_n && adv_n && !dq_oe && !done,
          "R1 idle after reset", {cs_n, oe_n, we_n, adv_n, dq_oe, done}, 6'b111100);

    // R2: setup skipped, R4: data length 0 clamps to 1, R5: no gap
    c_set = 0; c_dat = 0; c_turn = 0; c_mux = 0;
    run(0, 24'h00_1234, 0, 0, -1);
    run(1, 24'h00_1235, 32'hDEAD_BEEF, 0, -1);
    // R3: multiplexed, hold 0 clamps to 1, narrow widths (R7)
    c_mux = 1; c_hld = 0; c_set = 3; c_dat = 4; c_turn = 2; c_width = 0;
    run(0, 24'hAB_CDEF, 0, 0, -1);
    c_width = 1;
    run(1, 24'h12_3456, 32'hCAFE_F00D, 0, -1);
    c_width = 3; c_hld = 15; c_set = 15; c_turn = 15; c_dat = 255;
    run(0, 24'hFF_FFFF, 0, 0, -1);
    // R9: inhibited write
    c_mux = 0; c_set = 2; c_dat = 3; c_turn = 1; c_wen = 0;
    run(1, 24'h00_0F0F, 32'h1111_2222, 0, -1);
    c_turn = 0;
    run(1, 24'h00_0F10, 32'h3333_4444, 0, -1);
    c_wen = 1;
    // R11: request and inputs held or changed during the access
    run(0, 24'h55_AA55, 0, 1, -1);
    run(1, 24'h33_CC33, 32'h8765_4321, 1, -1);
    // R10: wait, active high then active low, short and long releases
    c_wait_en = 1; c_wait_pol = 1; c_dat = 2;
    run(0, 24'h00_2000, 0, 0, 5);
    c_dat = 20;
    run(1, 24'h00_2001, 32'h0BAD_CAFE, 0, 3);
    c_wait_pol = 0; c_dat = 1;
    run(0, 24'h00_2002, 0, 0, 0);
    c_wait_en = 0; c_dat = 3;
    // R10: wait ignored when disabled
    m_wait = 1'b1;
    run(0, 24'h00_3000, 0, 0, -1);
    m_wait = 1'b0;
    run(0, 24'h00_3001, 0, 0, -1);

    for (int i = 0; i < 40; i++) begin
      c_set   = 4'($urandom_range(0, 15));
      c_hld   = 4'($urandom_range(0, 15));
      c_dat   = 8'($urandom_range(0, 40));
      c_turn  = 4'($urandom_range(0, 15));
      c_mux   = 1'($urandom_range(0, 1));
      c_wen   = ($urandom_range(0, 5) != 0);
      c_width = 2'($urandom_range(0, 3));
      m_wait  = 1'($urandom_range(0, 1));
      run(1'($urandom_range(0, 1)), AW'($urandom), $urandom, 0, -1);
    end
    finish_run();
  end
endmodule